// File: doc/BRIEF.md
# Dual Page Buffer Flash Reader

This block is the read path between a system bus and a wide flash array. The array returns one 256-bit line of 32 bytes per fetch. The reader keeps two line buffers. Each buffer holds a tag and a valid flag. The first buffer serves every page whose top address bit is clear. The second serves every page whose top address bit is set. A bus read whose page is already buffered is answered on the next clock. A read that misses starts an array fetch in the same cycle, loads the buffer for that half, and is answered one clock later.

Writes are not allowed in normal operation. They are answered with an error and have no effect. A configuration input redirects accesses to a separate 256-byte shadow row that belongs to the lowest block. Shadow pages are tagged apart from normal pages. An invalidate strobe discards both buffers, for example after the array contents have been changed by other means.

Top module: `dpbf_reader`

## Requirements
- R1: The read word is bits [32k+31:32k] of the 256-bit line of the addressed page, where k = addr[4:2]. The normal page index is addr[15:5], and addr[1:0] has no effect.
- R2: Pages with addr[15]=0 use the lower buffer and pages with addr[15]=1 use the upper buffer. Filling one buffer never removes the page held by the other.
- R3: A read that hits a valid buffer raises ack, with rdata valid, on the clock after req is sampled. It issues no array fetch.
- R4: A read that misses raises arr_req for exactly one cycle, in the cycle req is presented. ack follows two clocks after req is sampled, and the page is then held in its buffer.
- R5: A write (we=1) raises err for one cycle on the clock after req is sampled. It raises no ack, issues no array fetch and leaves both buffers unchanged.
- R6: With shadow_en=1, fetches drive arr_shadow=1 and the shadow page index addr[7:5]. addr[15:8] has no effect, and shadow pages always use the lower buffer.
- R7: A shadow page and a normal page never hit each other's buffered data, whatever the order of toggling shadow_en.
- R8: A one-cycle inv pulse makes both buffers invalid, so the next read of any page misses. A read presented in the same cycle as inv is treated as a miss.
- R9: During and after reset, ack, err and arr_req are low and both buffers are invalid.
- R10: ack and err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus access request, held until ack or err |
| we | input | 1 | Access is a write |
| addr | input | 16 | Byte address |
| shadow_en | input | 1 | Map accesses to the shadow row |
| inv | input | 1 | Invalidate both buffers (one-cycle strobe) |
| ack | output | 1 | Read done, rdata valid this cycle |
| err | output | 1 | Access ended with a bus error |
| rdata | output | 32 | Read data word |
| arr_req | output | 1 | Array line fetch request |
| arr_shadow | output | 1 | Fetch targets the shadow row |
| arr_page | output | 11 | Page index of the fetch |
| arr_rdata | input | 256 | Line returned by the array one cycle after arr_req |

## Verification
A stale or corrupted tag or valid flag shows up at the ports on the very next read of that page. The symptoms are an ack one clock early with the wrong word, or a fetch pulse where none was due, or a missing fetch and a late ack. The bench keeps its own record of which page each half holds. It compares ack, err, rdata and the number of fetches against that record on every clock of every access. It also revisits pages after fills of the other half, after writes, after toggling shadow_en and after invalidation, so that a wrong buffer state is caught within one access.

// File: rtl/dpbf_pkg.sv
package dpbf_pkg;
    localparam int unsigned ADDR_W       = 16;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned LINE_BYTES   = 32;
    localparam int unsigned SHADOW_BYTES = 256;
    localparam int unsigned NUM_BUF      = 2;

    localparam int unsigned OFS_W     = $clog2(LINE_BYTES);
    localparam int unsigned LINE_W    = LINE_BYTES * 8;
    localparam int unsigned WSEL_W    = $clog2(LINE_W / WORD_W);
    localparam int unsigned PAGE_W    = ADDR_W - OFS_W;
    localparam int unsigned SHADOW_AW = $clog2(SHADOW_BYTES);
    localparam int unsigned BUF_IW    = $clog2(NUM_BUF);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [BUF_IW-1:0] bidx_t;

    typedef struct packed {
        logic              shadow;
        logic [PAGE_W-1:0] page;
    } tag_t;

    typedef enum logic {ST_IDLE, ST_FILL} state_t;

    function automatic tag_t tag_of(addr_t a, logic sh);
        tag_t t;
        t.shadow = sh;
        if (sh) t.page = PAGE_W'(a[SHADOW_AW-1:OFS_W]);
        else    t.page = a[ADDR_W-1:OFS_W];
        return t;
    endfunction

    function automatic bidx_t half_of(addr_t a, logic sh);
        return sh ? bidx_t'(0) : bidx_t'(a[ADDR_W-1]);
    endfunction

    function automatic wsel_t wsel_of(addr_t a);
        return a[OFS_W-1 -: WSEL_W];
    endfunction

    function automatic word_t pick(line_t l, wsel_t w);
        return l[int'(w)*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/dpbf_page_buf.sv
module dpbf_page_buf
    import dpbf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  inv,
    input  logic  fill_en,
    input  tag_t  fill_tag,
    input  line_t fill_line,
    input  tag_t  look_tag,
    input  wsel_t look_wsel,
    output logic  hit,
    output word_t word
);
    logic  valid;
    tag_t  tag;
    line_t data;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= '0;
        end else if (inv) begin
            valid <= 1'b0;
            if (fill_en) tag <= fill_tag;
        end else if (fill_en) begin
            valid <= 1'b1;
            tag   <= fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) data <= fill_line;
    end

    assign hit  = valid && (tag == look_tag);
    assign word = pick(data, look_wsel);

    // R8: invalidation leaves nothing to hit
    a_r8_inv_clears: assert property (@(posedge clk) disable iff (rst)
        inv |=> !hit);
    // R4: a fill without invalidation holds the new page
    a_r4_fill_kept: assert property (@(posedge clk) disable iff (rst)
        fill_en && !inv |=> valid && (tag == $past(fill_tag)));
    // R9: reset leaves the buffer empty
    a_r9_reset_empty: assert property (@(posedge clk)
        rst |=> !valid);
endmodule

// File: rtl/dpbf_ctrl.sv
module dpbf_ctrl
    import dpbf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  logic  we,
    input  logic  inv,
    input  tag_t  look_tag,
    input  bidx_t look_half,
    input  wsel_t look_wsel,
    input  logic  [NUM_BUF-1:0] hit_vec,
    input  word_t buf_word [NUM_BUF],
    input  line_t arr_rdata,
    output logic  [NUM_BUF-1:0] fill_vec,
    output tag_t  fill_tag,
    output logic  arr_req,
    output logic  ack,
    output logic  err,
    output word_t rdata
);
    state_t state;
    tag_t   pend_tag;
    bidx_t  pend_half;
    wsel_t  pend_wsel;

    logic idle, rd_go, look_hit, miss_go;

    assign idle     = (state == ST_IDLE);
    assign rd_go    = idle && req && !we;
    assign look_hit = hit_vec[look_half] && !inv;
    assign miss_go  = rd_go && !look_hit;
    assign arr_req  = miss_go;
    assign fill_tag = pend_tag;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_fill
        assign fill_vec[g] = (state == ST_FILL) && (pend_half == bidx_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ack       <= 1'b0;
            err       <= 1'b0;
            rdata     <= '0;
            pend_tag  <= '0;
            pend_half <= '0;
            pend_wsel <= '0;
        end else begin
            ack <= 1'b0;
            err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req && we) begin
                        err <= 1'b1;
                    end else if (rd_go && look_hit) begin
                        ack   <= 1'b1;
                        rdata <= buf_word[look_half];
                    end else if (miss_go) begin
                        state     <= ST_FILL;
                        pend_tag  <= look_tag;
                        pend_half <= look_half;
                        pend_wsel <= look_wsel;
                    end
                end
                ST_FILL: begin
                    ack   <= 1'b1;
                    rdata <= pick(arr_rdata, pend_wsel);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: hit answered on the next clock
    a_r3_hit_one_clock: assert property (@(posedge clk) disable iff (rst)
        rd_go && look_hit |=> ack && !err);
    // R4: miss answered on the second clock
    a_r4_miss_two_clocks: assert property (@(posedge clk) disable iff (rst)
        miss_go |=> !ack ##1 ack);
    // R4: one fetch pulse per miss
    a_r4_single_fetch: assert property (@(posedge clk) disable iff (rst)
        arr_req |=> !arr_req && !ack);
    // R5: write ends in an error only
    a_r5_write_err: assert property (@(posedge clk) disable iff (rst)
        idle && req && we |=> err && !ack);
    // R10: responses exclusive
    a_r10_one_response: assert property (@(posedge clk) disable iff (rst)
        !(ack && err));
endmodule

// File: rtl/dpbf_reader.sv
module dpbf_reader
    import dpbf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  shadow_en,
    input  logic                  inv,
    output logic                  ack,
    output logic                  err,
    output logic [WORD_W-1:0]     rdata,
    output logic                  arr_req,
    output logic                  arr_shadow,
    output logic [PAGE_W-1:0]     arr_page,
    input  logic [LINE_W-1:0]     arr_rdata
);
    tag_t  look_tag, fill_tag;
    bidx_t look_half;
    wsel_t look_wsel;
    logic  [NUM_BUF-1:0] hit_vec, fill_vec;
    word_t buf_word [NUM_BUF];

    assign look_tag   = tag_of(addr, shadow_en);
    assign look_half  = half_of(addr, shadow_en);
    assign look_wsel  = wsel_of(addr);
    assign arr_shadow = look_tag.shadow;
    assign arr_page   = look_tag.page;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        dpbf_page_buf u_buf (
            .clk       (clk),
            .rst       (rst),
            .inv       (inv),
            .fill_en   (fill_vec[g]),
            .fill_tag  (fill_tag),
            .fill_line (arr_rdata),
            .look_tag  (look_tag),
            .look_wsel (look_wsel),
            .hit       (hit_vec[g]),
            .word      (buf_word[g])
        );
    end

    dpbf_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .we        (we),
        .inv       (inv),
        .look_tag  (look_tag),
        .look_half (look_half),
        .look_wsel (look_wsel),
        .hit_vec   (hit_vec),
        .buf_word  (buf_word),
        .arr_rdata (arr_rdata),
        .fill_vec  (fill_vec),
        .fill_tag  (fill_tag),
        .arr_req   (arr_req),
        .ack       (ack),
        .err       (err),
        .rdata     (rdata)
    );
endmodule

// File: tb/dpbf_reader_bench.sv
module dpbf_reader_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req = 1'b0;
    logic         we = 1'b0;
    logic [15:0]  addr = '0;
    logic         shadow_en = 1'b0;
    logic         inv = 1'b0;
    logic         ack, err, arr_req, arr_shadow;
    logic [31:0]  rdata;
    logic [10:0]  arr_page;
    logic [255:0] arr_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int fetch_cnt = 0;

    // reference record of buffered pages: index 0 lower, 1 upper
    bit m_valid [2];
    bit m_sh    [2];
    int m_page  [2];

    always #4 clk = ~clk;

    dpbf_reader u_dpbf_reader (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .shadow_en(shadow_en), .inv(inv), .ack(ack), .err(err),
        .rdata(rdata), .arr_req(arr_req), .arr_shadow(arr_shadow),
        .arr_page(arr_page), .arr_rdata(arr_rdata)
    );

    function automatic logic [31:0] mk_word(bit sh, int page, int w);
        return {sh ? 8'h5A : 8'hC3, 5'd0, 11'(page), 5'd0, 3'(w)};
    endfunction

    function automatic logic [255:0] mk_line(bit sh, int page);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = mk_word(sh, page, i);
        return l;
    endfunction

    // array model: line valid one cycle after the request
    always @(posedge clk) begin
        if (arr_req) begin
            arr_rdata <= mk_line(arr_shadow, int'(arr_page));
            fetch_cnt <= fetch_cnt + 1;
        end
    end

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic model_clear();
        m_valid[0] = 0;
        m_valid[1] = 0;
    endtask

    // called at a falling edge; returns at the falling edge of the response
    task automatic access(bit w, logic [15:0] a, bit sh, bit with_inv, string rq);
        int half, page, lat, f0, wsel;
        bit hit;
        half = sh ? 0 : int'(a[15]);
        page = sh ? int'(a[7:5]) : int'(a[15:5]);
        wsel = int'(a[4:2]);
        if (with_inv) model_clear();
        hit = m_valid[half] && (m_sh[half] == sh) && (m_page[half] == page);
        lat = (w || hit) ? 1 : 2;
        f0 = fetch_cnt;
        req = 1'b1; we = w; addr = a; shadow_en = sh; inv = with_inv;
        for (int c = 1; c <= lat; c++) begin
            @(negedge clk);
            inv = 1'b0;
            if (c < lat) begin
                chk(!ack && !err, rq, "early response", {30'd0, ack, err}, 32'd0);
            end else if (w) begin
                chk(err && !ack, rq, "write error", {30'd0, ack, err}, 32'd1);
            end else begin
                chk(ack && !err, rq, "read ack timing", {30'd0, ack, err}, 32'd2);
                chk(rdata == mk_word(sh, page, wsel), rq, "read data", rdata, mk_word(sh, page, wsel));
            end
        end
        req = 1'b0; we = 1'b0;
        chk(fetch_cnt - f0 == ((!w && !hit) ? 1 : 0), rq, "fetch count",
            32'(fetch_cnt - f0), (!w && !hit) ? 32'd1 : 32'd0);
        if (!w && !hit) begin
            m_valid[half] = 1; m_sh[half] = sh; m_page[half] = page;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ack && !err && !arr_req, "R9", "outputs in reset", {29'd0, ack, err, arr_req}, 32'd0);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        chk(!ack && !err && !arr_req, "R9", "outputs after reset", {29'd0, ack, err, arr_req}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();
        // R9: first read after reset misses
        access(0, 16'h0104, 0, 0, "R9");
        // R3, R1: same page hits, other word
        access(0, 16'h0118, 0, 0, "R3");
        // R1: low address bits ignored
        access(0, 16'h0107, 0, 0, "R1");
        // R4, R2: upper page fills upper buffer, lower still hits
        access(0, 16'h8220, 0, 0, "R4");
        access(0, 16'h011C, 0, 0, "R2");
        access(0, 16'h823C, 0, 0, "R2");
        // R2: new lower page evicts lower only
        access(0, 16'h0400, 0, 0, "R2");
        access(0, 16'h8230, 0, 0, "R2");
        access(0, 16'h0104, 0, 0, "R2");
        // R5: writes error, no fetch, buffers intact
        access(1, 16'h823C, 0, 0, "R5");
        access(1, 16'h4000, 0, 0, "R5");
        access(0, 16'h8234, 0, 0, "R5");
        access(0, 16'h0100, 0, 0, "R5");
        // R6: shadow row
        access(0, 16'h0104, 1, 0, "R6");
        access(0, 16'hFF08, 1, 0, "R6");
        access(0, 16'h8230, 0, 0, "R6");
        access(0, 16'h00E0, 1, 0, "R6");
        // R7: normal and shadow do not alias
        access(0, 16'h00E4, 0, 0, "R7");
        access(0, 16'h00E4, 1, 0, "R7");
        access(0, 16'h00E8, 1, 0, "R7");
        // R8: invalidate pulse
        @(negedge clk);
        inv = 1'b1;
        @(negedge clk);
        inv = 1'b0;
        model_clear();
        access(0, 16'h8230, 0, 0, "R8");
        access(0, 16'h8238, 0, 0, "R8");
        // R8: request alongside invalidate misses
        access(0, 16'h8230, 0, 1, "R8");
        access(0, 16'h8234, 0, 0, "R8");
        // R10: back-to-back read then write
        access(0, 16'h8234, 0, 0, "R10");
        access(1, 16'h8234, 0, 0, "R10");
        // R9: reset empties buffers
        do_reset();
        access(0, 16'h8230, 0, 0, "R9");
        access(0, 16'h8230, 0, 0, "R3");
        repeat (2) @(negedge clk);
        summary();
    end
endmodule